// File: doc/BRIEF.md
# UART FIFO status and interrupt controller

This block turns the occupancy counts of a UART's receive and transmit FIFOs into a live status word. It compares each count against empty, full and a programmable trigger level. Every clock cycle, the live flags and a set of error and event pulses are merged into a sticky interrupt status register. Software clears that register by writing ones to the bits it wants cleared.

The interrupt mask cannot be written directly. It changes only through an enable port, which sets bits, and a disable port, which clears bits. A single registered interrupt line goes high while any masked sticky bit is set. The two trigger levels are held in registers inside the block and can be read back.

The transmit-trigger flag appears at bit 13 of the live status word but at bit 10 of the sticky word. Logic that decodes either word must use the matching position.

Top module: `uart_irq_status`

## Requirements
- R1: `statusWord` is combinational from the current inputs and register contents:
  - bit 0 is `rxCount >= rxTrigLevel`;
  - bit 1 is `rxCount == 0`;
  - bit 2 is `rxCount == FIFO_DEPTH`;
  - bit 3 is `txCount == 0`;
  - bit 4 is `txCount == FIFO_DEPTH`;
  - bit 13 is `txCount >= txTrigLevel`;
  - all other bits are 0.
- R2: At every clock edge, live status bits 4:0 are ORed into sticky bits 4:0 at the same positions.
- R3: A set live bit 13 (transmit trigger) sets sticky bit 10 at the next edge.
- R4: The event pulses set sticky bits at the next edge, as follows:
  - `rxOverrun` sets bit 5;
  - `framingErr` sets bit 6;
  - `parityErr` sets bit 7;
  - `rxTimeout` sets bit 8;
  - `modemChange` sets bit 9;
  - `txOverrun` sets bit 12.
  - Sticky bit 11 always reads 0.
- R5: A mask-enable write ORs its data into the mask. A mask-disable write clears the mask bits written as 1. When both writes happen in the same cycle, the disable is applied after the enable, so disable wins on a shared bit.
- R6: A sticky-clear write clears, at the next edge, every sticky bit written as 1. Bits written as 0 are left unchanged.
- R7: If a clear and a new set for the same sticky bit happen in the same cycle, the bit is set after the edge.
- R8: `irq` is registered. At each edge it takes the value (mask AND sticky) != 0, using the mask and sticky values held before that edge.
- R9: While reset is asserted:
  - mask, sticky and `irq` read 0;
  - both trigger levels read `TRIG_RESET` (default 32).
- R10: A write to `rxTrigData` or `txTrigData` with its strobe set loads the trigger level at the next edge. The new level is read back on `rxTrigLevel` or `txTrigLevel` and is used by R1 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| txCount | input | CNT_W | Transmit FIFO occupancy |
| rxOverrun | input | 1 | Receive overrun pulse |
| txOverrun | input | 1 | Transmit overrun pulse |
| rxTimeout | input | 1 | Receive timeout pulse |
| framingErr | input | 1 | Framing error pulse |
| parityErr | input | 1 | Parity error pulse |
| modemChange | input | 1 | Modem status change pulse |
| maskEnWr | input | 1 | Mask-enable write strobe |
| maskEnData | input | 13 | Bits to set in the mask |
| maskDisWr | input | 1 | Mask-disable write strobe |
| maskDisData | input | 13 | Bits to clear in the mask |
| stickyClrWr | input | 1 | Sticky-clear write strobe |
| stickyClrData | input | 13 | Sticky bits to clear |
| rxTrigWr | input | 1 | Receive trigger level write strobe |
| rxTrigData | input | CNT_W | New receive trigger level |
| txTrigWr | input | 1 | Transmit trigger level write strobe |
| txTrigData | input | CNT_W | New transmit trigger level |
| statusWord | output | 14 | Live status flags |
| maskWord | output | 13 | Interrupt mask |
| stickyWord | output | 13 | Sticky interrupt status |
| rxTrigLevel | output | CNT_W | Current receive trigger level |
| txTrigLevel | output | CNT_W | Current transmit trigger level |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `FIFO_DEPTH` = 40 and `TRIG_RESET` = 32, which gives 6-bit counts. With these values the reset trigger level of 32 fits in the count width and lies strictly between empty and full.

Every pair of RX and TX counts from 0 to 40 is swept under four pairs of trigger levels. The sweep includes a level of 0, which makes a trigger flag always true, and a level above the depth, which makes it never true. This reaches every combination of empty, full and trigger comparisons.

During the sweep, event patterns change from step to step and full clears are applied on alternate steps. This exercises the rule that a same-cycle set beats a clear, and it makes `irq` both rise and fall.

// File: rtl/uis_pkg.sv
package uis_pkg;
  localparam int IRQ_W  = 13;
  localparam int STAT_W = 14;

  // bit positions shared with downstream decoders
  localparam int B_RXTRIG      = 0;
  localparam int B_RXEMPTY     = 1;
  localparam int B_RXFULL      = 2;
  localparam int B_TXEMPTY     = 3;
  localparam int B_TXFULL      = 4;
  localparam int B_RXOVR       = 5;
  localparam int B_FRAME       = 6;
  localparam int B_PARITY      = 7;
  localparam int B_TIMEOUT     = 8;
  localparam int B_MODEM       = 9;
  localparam int B_TXTRIG_IRQ  = 10;
  localparam int B_TXOVR       = 12;
  localparam int B_TXTRIG_STAT = 13;
  localparam int LIVE_IRQ_BITS = 5;

  typedef struct packed {
    logic [IRQ_W-1:0] maskSet;
    logic [IRQ_W-1:0] maskClr;
    logic [IRQ_W-1:0] stickyClr;
    logic [IRQ_W-1:0] stickySet;
    logic             rxTrigWr;
    logic             txTrigWr;
  } regStrobes_t;
endpackage

// File: rtl/uis_ctrl.sv
module uis_ctrl
  import uis_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxTrigLevel,
  input  logic [CNT_W-1:0]  txTrigLevel,
  input  logic              rxOverrun,
  input  logic              txOverrun,
  input  logic              rxTimeout,
  input  logic              framingErr,
  input  logic              parityErr,
  input  logic              modemChange,
  input  logic              maskEnWr,
  input  logic [IRQ_W-1:0]  maskEnData,
  input  logic              maskDisWr,
  input  logic [IRQ_W-1:0]  maskDisData,
  input  logic              stickyClrWr,
  input  logic [IRQ_W-1:0]  stickyClrData,
  input  logic              rxTrigWr,
  input  logic              txTrigWr,
  output logic [STAT_W-1:0] liveStatus,
  output regStrobes_t       strobes
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    liveStatus                = '0;
    liveStatus[B_RXTRIG]      = (rxCount >= rxTrigLevel);
    liveStatus[B_RXEMPTY]     = (rxCount == '0);
    liveStatus[B_RXFULL]      = (rxCount == FULL_CNT);
    liveStatus[B_TXEMPTY]     = (txCount == '0);
    liveStatus[B_TXFULL]      = (txCount == FULL_CNT);
    liveStatus[B_TXTRIG_STAT] = (txCount >= txTrigLevel);
  end

  always_comb begin
    strobes           = '0;
    strobes.maskSet   = maskEnWr    ? maskEnData    : '0;
    strobes.maskClr   = maskDisWr   ? maskDisData   : '0;
    strobes.stickyClr = stickyClrWr ? stickyClrData : '0;
    strobes.rxTrigWr  = rxTrigWr;
    strobes.txTrigWr  = txTrigWr;
    strobes.stickySet[LIVE_IRQ_BITS-1:0] = liveStatus[LIVE_IRQ_BITS-1:0];
    strobes.stickySet[B_TXTRIG_IRQ] = liveStatus[B_TXTRIG_STAT];
    strobes.stickySet[B_RXOVR]      = rxOverrun;
    strobes.stickySet[B_FRAME]      = framingErr;
    strobes.stickySet[B_PARITY]     = parityErr;
    strobes.stickySet[B_TIMEOUT]    = rxTimeout;
    strobes.stickySet[B_MODEM]      = modemChange;
    strobes.stickySet[B_TXOVR]      = txOverrun;
  end

  // R1: an in-range count cannot be both empty and full
  a_r1_empty_full_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(liveStatus[B_RXEMPTY] && liveStatus[B_RXFULL]) &&
    !(liveStatus[B_TXEMPTY] && liveStatus[B_TXFULL]));
endmodule

// File: rtl/uis_datapath.sv
module uis_datapath
  import uis_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int TRIG_RESET = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  logic [CNT_W-1:0] rxTrigData,
  input  logic [CNT_W-1:0] txTrigData,
  output logic [IRQ_W-1:0] maskQ,
  output logic [IRQ_W-1:0] stickyQ,
  output logic [CNT_W-1:0] rxTrigQ,
  output logic [CNT_W-1:0] txTrigQ,
  output logic             irqQ
);
  localparam logic [CNT_W-1:0] TRIG_INIT = CNT_W'(TRIG_RESET);

  logic anyPending;
  assign anyPending = |(maskQ & stickyQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      stickyQ <= '0;
      irqQ    <= 1'b0;
      rxTrigQ <= TRIG_INIT;
      txTrigQ <= TRIG_INIT;
    end else begin
      maskQ   <= (maskQ | strobes.maskSet) & ~strobes.maskClr;
      stickyQ <= (stickyQ & ~strobes.stickyClr) | strobes.stickySet;
      irqQ    <= anyPending;
      if (strobes.rxTrigWr) rxTrigQ <= rxTrigData;
      if (strobes.txTrigWr) txTrigQ <= txTrigData;
    end
  end

  // R7: a bit being set wins over a same-cycle clear
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stickyQ & $past(strobes.stickySet)) == $past(strobes.stickySet)));

  // R6: sticky bits fall only where a clear was written
  a_r6_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(stickyQ) & ~stickyQ & ~$past(strobes.stickyClr)) == '0));

  // R5: disable has the last word on the mask
  a_r5_disable_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.maskClr) |=> ((maskQ & $past(strobes.maskClr)) == '0));

  // R8: registered interrupt follows masked status one cycle later
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |=> irqQ);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !anyPending |=> !irqQ);

  // R4: the unused sticky position never becomes set
  a_r4_gap_bit: assert property (@(posedge clk) disable iff (!rstN)
    $past(stickyQ[11]) == 1'b0 |-> stickyQ[11] == 1'b0);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uis_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_RESET = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              rxOverrun,
  input  logic              txOverrun,
  input  logic              rxTimeout,
  input  logic              framingErr,
  input  logic              parityErr,
  input  logic              modemChange,
  input  logic              maskEnWr,
  input  logic [12:0]       maskEnData,
  input  logic              maskDisWr,
  input  logic [12:0]       maskDisData,
  input  logic              stickyClrWr,
  input  logic [12:0]       stickyClrData,
  input  logic              rxTrigWr,
  input  logic [CNT_W-1:0]  rxTrigData,
  input  logic              txTrigWr,
  input  logic [CNT_W-1:0]  txTrigData,
  output logic [13:0]       statusWord,
  output logic [12:0]       maskWord,
  output logic [12:0]       stickyWord,
  output logic [CNT_W-1:0]  rxTrigLevel,
  output logic [CNT_W-1:0]  txTrigLevel,
  output logic              irq
);
  regStrobes_t strobes;

  uis_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .rxCount(rxCount), .txCount(txCount),
    .rxTrigLevel(rxTrigLevel), .txTrigLevel(txTrigLevel),
    .rxOverrun(rxOverrun), .txOverrun(txOverrun), .rxTimeout(rxTimeout),
    .framingErr(framingErr), .parityErr(parityErr), .modemChange(modemChange),
    .maskEnWr(maskEnWr), .maskEnData(maskEnData),
    .maskDisWr(maskDisWr), .maskDisData(maskDisData),
    .stickyClrWr(stickyClrWr), .stickyClrData(stickyClrData),
    .rxTrigWr(rxTrigWr), .txTrigWr(txTrigWr),
    .liveStatus(statusWord), .strobes(strobes)
  );

  uis_datapath #(.CNT_W(CNT_W), .TRIG_RESET(TRIG_RESET)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxTrigData(rxTrigData), .txTrigData(txTrigData),
    .maskQ(maskWord), .stickyQ(stickyWord),
    .rxTrigQ(rxTrigLevel), .txTrigQ(txTrigLevel), .irqQ(irq)
  );
endmodule

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 40;
  localparam int TRIG_INIT  = 32;
  localparam int CW         = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] rxCount = '0, txCount = '0, rxTrigData = '0, txTrigData = '0;
  logic rxOverrun = 0, txOverrun = 0, rxTimeout = 0, framingErr = 0;
  logic parityErr = 0, modemChange = 0;
  logic maskEnWr = 0, maskDisWr = 0, stickyClrWr = 0, rxTrigWr = 0, txTrigWr = 0;
  logic [12:0] maskEnData = '0, maskDisData = '0, stickyClrData = '0;
  logic [13:0] statusWord;
  logic [12:0] maskWord, stickyWord;
  logic [CW-1:0] rxTrigLevel, txTrigLevel;
  logic irq;

  uart_irq_status #(.FIFO_DEPTH(DEPTH), .TRIG_RESET(TRIG_INIT)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [12:0] expMask = '0, expSticky = '0;
  logic expIrq = 0;
  int expRt = TRIG_INIT, expTt = TRIG_INIT;
  string curTag = "R2";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] liveExp();
    logic [13:0] v = '0;
    v[0]  = int'(rxCount) >= expRt;
    v[1]  = rxCount == 0;
    v[2]  = int'(rxCount) == DEPTH;
    v[3]  = txCount == 0;
    v[4]  = int'(txCount) == DEPTH;
    v[13] = int'(txCount) >= expTt;
    return v;
  endfunction

  task automatic tick();
    logic [13:0] l = liveExp();
    logic [12:0] s = '0;
    s[4:0] = l[4:0]; s[10] = l[13];
    s[5] = rxOverrun; s[6] = framingErr; s[7] = parityErr;
    s[8] = rxTimeout; s[9] = modemChange; s[12] = txOverrun;
    expIrq = |(expMask & expSticky);
    expMask = (expMask | (maskEnWr ? maskEnData : 13'h0)) & ~(maskDisWr ? maskDisData : 13'h0);
    expSticky = (expSticky & ~(stickyClrWr ? stickyClrData : 13'h0)) | s;
    if (rxTrigWr) expRt = int'(rxTrigData);
    if (txTrigWr) expTt = int'(txTrigData);
    @(posedge clk);
    @(negedge clk);
    maskEnWr = 0; maskDisWr = 0; stickyClrWr = 0; rxTrigWr = 0; txTrigWr = 0;
    {rxOverrun, txOverrun, rxTimeout, framingErr, parityErr, modemChange} = '0;
    chk(curTag, 32'(stickyWord), 32'(expSticky));
    chk("R5", 32'(maskWord), 32'(expMask));
    chk("R8", 32'(irq), 32'(expIrq));
    chk("R10", 32'(rxTrigLevel), 32'(expRt));
    chk("R10", 32'(txTrigLevel), 32'(expTt));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9", 32'(maskWord), 0);
    chk("R9", 32'(stickyWord), 0);
    chk("R9", 32'(irq), 0);
    chk("R9", 32'(rxTrigLevel), TRIG_INIT);
    chk("R9", 32'(txTrigLevel), TRIG_INIT);
    rstN = 1;
    curTag = "R2"; tick(); tick();
    chk("R2", 32'(stickyWord), 32'h00A);

    // R5 mask set / clear / both
    maskEnWr = 1; maskEnData = 13'h0F0; tick();
    chk("R5", 32'(maskWord), 32'h0F0);
    maskDisWr = 1; maskDisData = 13'h030; tick();
    chk("R5", 32'(maskWord), 32'h0C0);
    maskEnWr = 1; maskEnData = 13'h003; maskDisWr = 1; maskDisData = 13'h001; tick();
    chk("R5", 32'(maskWord), 32'h0C2);
    maskDisWr = 1; maskDisData = 13'h1FFF; tick();

    // R10 trigger writes
    curTag = "R10";
    rxTrigWr = 1; rxTrigData = 5; txTrigWr = 1; txTrigData = 7; tick();
    chk("R10", 32'(rxTrigLevel), 5);

    // R6 clear of bits not driven live
    curTag = "R6";
    rxCount = 1; txCount = 1; tick();
    stickyClrWr = 1; stickyClrData = 13'h00A; tick();
    chk("R6", 32'(stickyWord), 32'h0);

    // R4 each event alone
    curTag = "R4";
    rxOverrun = 1; tick(); chk("R4", 32'(stickyWord[5]), 1);
    framingErr = 1; tick(); chk("R4", 32'(stickyWord[6]), 1);
    parityErr = 1; tick(); chk("R4", 32'(stickyWord[7]), 1);
    rxTimeout = 1; tick(); chk("R4", 32'(stickyWord[8]), 1);
    modemChange = 1; tick(); chk("R4", 32'(stickyWord[9]), 1);
    txOverrun = 1; tick(); chk("R4", 32'(stickyWord[12]), 1);
    chk("R4", 32'(stickyWord[11]), 0);
    stickyClrWr = 1; stickyClrData = 13'h1FFF; tick();

    // R7 set beats clear
    curTag = "R7";
    rxOverrun = 1; stickyClrWr = 1; stickyClrData = 13'h020; tick();
    chk("R7", 32'(stickyWord[5]), 1);

    // R8 latency: enable mask on a set bit, irq one cycle later
    curTag = "R8";
    maskEnWr = 1; maskEnData = 13'h020; tick();
    chk("R8", 32'(irq), 0);
    tick();
    chk("R8", 32'(irq), 1);

    // R3 transmit trigger lands at bit 10
    curTag = "R3";
    stickyClrWr = 1; stickyClrData = 13'h1FFF; txCount = 7; tick();
    chk("R3", 32'(stickyWord[10]), 1);
    chk("R1", 32'(statusWord[13]), 1);
    chk("R1", 32'(statusWord[12:5]), 0);

    // sweep: R1 R2 R3 R4 R7 R8 under four trigger pairs
    maskEnWr = 1; maskEnData = 13'h1FFF; maskDisWr = 1; maskDisData = 13'h1BFB; tick();
    for (int t = 0; t < 4; t++) begin
      rxTrigWr = 1; txTrigWr = 1;
      case (t)
        0: begin rxTrigData = 0;  txTrigData = 40; end
        1: begin rxTrigData = 5;  txTrigData = 0;  end
        2: begin rxTrigData = 32; txTrigData = 17; end
        default: begin rxTrigData = 63; txTrigData = 32; end
      endcase
      curTag = "R10"; tick();
      curTag = "R2";
      for (int rx = 0; rx <= DEPTH; rx++) begin
        for (int tx = 0; tx <= DEPTH; tx++) begin
          logic [5:0] ev;
          rxCount = CW'(rx); txCount = CW'(tx);
          ev = 6'((rx * 3 + tx * 5) % 64);
          {rxOverrun, txOverrun, rxTimeout, framingErr, parityErr, modemChange} = ev;
          stickyClrWr = ((rx + tx) % 2) == 1; stickyClrData = 13'h1FFF;
          #1;
          chk("R1", 32'(statusWord), 32'(liveExp()));
          tick();
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule